// File: doc/BRIEF.md
# Type-C Source Connection State Machine

This block runs the connection logic of a source-only Type-C port that also accepts accessories. Each configuration-channel pin feeds three comparator results into it. It sorts each pin into open, sink termination (Rd) or low-impedance termination (Ra), and the Rd/Ra boundary depends on the pull-up current the port is advertising. A stable pin pattern must persist through an attach debounce before the port counts as attached. A single Rd makes a source-to-sink connection, Ra on both pins makes an audio accessory, and Rd on both pins makes a debug accessory. A debug accessory is first reported unoriented and becomes oriented in a later step.

Once attached, the block reports the cable orientation for an open-drain pad and routes the VCONN switch to the pin that carries no Rd. It raises a flag that allows the power path, and it watches for detach with a shorter debounce. Any fault condition sends the machine into a timed error-recovery window. In that window the terminations are released and the power path is withdrawn. The machine then returns to the unattached state. A discharge request goes up on every detach and on every entry into error recovery.

Top module: `typec_src_ctrl`

## Requirements
- R1: While `rst` is high both termination enables are 0. After reset the port is unattached: `att_mode`=0, `pwr_ok`=0, `orient_pull_low`=0, and both terminations are enabled (`term_en`=2'b11).
- R2: Pin classification, where cmp bit0 = below the Ra threshold used for default and 1.5 A, bit1 = below the Ra threshold used for 3.0 A, and bit2 = below the open threshold. The pin is Ra if the bit for the current level is set, else Rd if bit2 is set, else open.
- R3: An attach completes after the pattern has been stable for ATT_DEB_CYC cycles. The mode changes exactly ATT_DEB_CYC+2 clocks after the pins change. Any change of pattern while waiting restarts the wait.
- R4: A sink or debug attach completes only while `vbus_safe0` is high. An audio attach does not need it.
- R5: `att_mode` codes are 0 none, 1 sink, 2 audio, 3 debug unoriented, 4 debug oriented. With a sink, `orient_pull_low` is 1 when Rd is on CC2 and 0 (released) when Rd is on CC1. `vconn_en` (bit0 = CC1) enables only the pin opposite the Rd.
- R6: Ra on both pins gives `att_mode`=2, with no power path and no VCONN.
- R7: Rd on both pins gives `att_mode`=3. When one pin then reads Ra and the other Rd, the mode becomes 4, and `orient_pull_low`=1 if the Ra pin is CC2.
- R8: A detach is taken after DET_DEB_CYC+1 clocks of missing termination. For a sink the missing termination is no Rd on the sink pin, for audio it is not Ra/Ra, and for debug it is both pins open. The detach sets `disch_req`, which clears once the machine is unattached and `vbus_safe0` is high.
- R9: Overtemperature, pull-up supply undervoltage or CC overvoltage, in any state, enters error recovery on the next clock. Error recovery lasts ERR_REC_CYC clocks with `term_en`=0, `pwr_ok`=0, `vconn_en`=0 and `disch_req`=1, then the machine returns to unattached.
- R10: In modes 1, 3 and 4, a low `vbus_ok` is ignored for VBUS_GRACE_CYC clocks after entry. After that a low `vbus_ok` causes error recovery.
- R11: In modes 1, 3 and 4, `vdd_uv` or `vdd_ov` causes error recovery only when its enable input is high.
- R12: `rp_level` follows `cur_sel` one clock later: 0 default, 1 1.5 A, 2 3.0 A, and a `cur_sel` of 3 is taken as 3.0 A.
- R13: `pwr_ok` is high only in modes 1, 3 and 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cur_sel | input | 2 | Requested pull-up current level |
| cc1_cmp | input | 3 | CC1 comparator results |
| cc2_cmp | input | 3 | CC2 comparator results |
| vbus_ok | input | 1 | VBUS inside its valid window |
| vbus_safe0 | input | 1 | VBUS at safe zero level |
| ot_flt | input | 1 | Overtemperature |
| pu_uv_flt | input | 1 | CC pull-up supply undervoltage |
| cc_ov_flt | input | 1 | CC pin overvoltage |
| vdd_uv | input | 1 | Supply undervoltage detected |
| vdd_ov | input | 1 | Supply overvoltage detected |
| vdd_uv_en | input | 1 | Enable the supply undervoltage check |
| vdd_ov_en | input | 1 | Enable the supply overvoltage check |
| rp_level | output | 2 | Advertised current level |
| term_en | output | 2 | Pull-up enable per pin (bit0 = CC1) |
| vconn_en | output | 2 | VCONN switch per pin (bit0 = CC1) |
| orient_pull_low | output | 1 | 1 drives the orientation pad low, 0 releases it |
| att_mode | output | 3 | Attached-mode code |
| pwr_ok | output | 1 | Power path allowed |
| disch_req | output | 1 | VBUS discharge request |

## Verification
The bench builds the block with ATT_DEB_CYC=16, DET_DEB_CYC=6, ERR_REC_CYC=10 and VBUS_GRACE_CYC=20. The real-time defaults would need tens of millions of clocks, and these short windows let every debounce, recovery and grace boundary be checked on the exact clock where it ends. With such short windows, random pin-voltage pairs under both current levels can each run through attach and detach. Directed cases then cover restarting the debounce, waiting for safe zero volts, debug orientation and every fault source.

// File: rtl/typec_src_pkg.sv
package typec_src_pkg;

  typedef enum logic [1:0] {
    CC_OPEN = 2'd0,
    CC_RD   = 2'd1,
    CC_RA   = 2'd2
  } cc_term_e;

  typedef enum logic [1:0] {
    RP_DEF = 2'd0,
    RP_1A5 = 2'd1,
    RP_3A0 = 2'd2
  } rp_lvl_e;

  typedef enum logic [2:0] {
    ST_UNATT,
    ST_ATTWAIT,
    ST_SRC,
    ST_AUDIO,
    ST_DBG_UN,
    ST_DBG_OR,
    ST_ERR
  } src_st_e;

  typedef enum logic [1:0] {
    PAT_NONE,
    PAT_SINK,
    PAT_AUDIO,
    PAT_DEBUG
  } pat_kind_e;

  localparam logic [2:0] MODE_NONE   = 3'd0;
  localparam logic [2:0] MODE_SINK   = 3'd1;
  localparam logic [2:0] MODE_AUDIO  = 3'd2;
  localparam logic [2:0] MODE_DBG_UN = 3'd3;
  localparam logic [2:0] MODE_DBG_OR = 3'd4;

  function automatic pat_kind_e pat_of(input cc_term_e a, input cc_term_e b);
    if (a == CC_RA && b == CC_RA)      return PAT_AUDIO;
    else if (a == CC_RD && b == CC_RD) return PAT_DEBUG;
    else if (a == CC_RD || b == CC_RD) return PAT_SINK;
    else                               return PAT_NONE;
  endfunction

endpackage

// File: rtl/typec_cc_class.sv
module typec_cc_class
  import typec_src_pkg::*;
#(
  parameter int NCMP = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NCMP-1:0] cmp,
  input  logic            hi_cur,
  output cc_term_e        term
);
  // bit0: below Ra level for default/1.5 A, bit1: below Ra level for 3.0 A,
  // bit2: below open level
  logic ra_hit;
  assign ra_hit = hi_cur ? cmp[1] : cmp[0];

  always_ff @(posedge clk) begin
    if (rst)         term <= CC_OPEN;
    else if (ra_hit) term <= CC_RA;
    else if (cmp[2]) term <= CC_RD;
    else             term <= CC_OPEN;
  end
endmodule

// File: rtl/typec_sat_timer.sv
module typec_sat_timer #(
  parameter int LIMIT = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic en,
  output logic done
);
  localparam int W = $clog2(LIMIT + 1);
  localparam logic [W-1:0] TERM = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  assign done = (cnt == TERM);

  always_ff @(posedge clk) begin
    if (rst || clr)      cnt <= '0;
    else if (en && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/typec_src_ctrl.sv
module typec_src_ctrl
  import typec_src_pkg::*;
#(
  parameter int ATT_DEB_CYC    = 37_500_000,
  parameter int DET_DEB_CYC    = 2_500_000,
  parameter int ERR_REC_CYC    = 6_250_000,
  parameter int VBUS_GRACE_CYC = 75_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] cur_sel,
  input  logic [2:0] cc1_cmp,
  input  logic [2:0] cc2_cmp,
  input  logic       vbus_ok,
  input  logic       vbus_safe0,
  input  logic       ot_flt,
  input  logic       pu_uv_flt,
  input  logic       cc_ov_flt,
  input  logic       vdd_uv,
  input  logic       vdd_ov,
  input  logic       vdd_uv_en,
  input  logic       vdd_ov_en,
  output logic [1:0] rp_level,
  output logic [1:0] term_en,
  output logic [1:0] vconn_en,
  output logic       orient_pull_low,
  output logic [2:0] att_mode,
  output logic       pwr_ok,
  output logic       disch_req
);
  localparam int NPIN = 2;
  localparam int NCMP = 3;

  // current level register
  rp_lvl_e rp_r;
  always_ff @(posedge clk) begin
    if (rst)                  rp_r <= RP_DEF;
    else if (cur_sel == 2'd3) rp_r <= RP_3A0;
    else                      rp_r <= rp_lvl_e'(cur_sel);
  end
  assign rp_level = rp_r;

  // per-pin classification
  logic [NCMP-1:0] cmp_in [NPIN];
  cc_term_e        cls    [NPIN];
  assign cmp_in[0] = cc1_cmp;
  assign cmp_in[1] = cc2_cmp;

  for (genvar p = 0; p < NPIN; p++) begin : g_pin
    typec_cc_class #(.NCMP(NCMP)) u_cls (
      .clk    (clk),
      .rst    (rst),
      .cmp    (cmp_in[p]),
      .hi_cur (rp_r == RP_3A0),
      .term   (cls[p])
    );
  end

  pat_kind_e pat_now;
  logic      sink_now;
  assign pat_now  = pat_of(cls[0], cls[1]);
  assign sink_now = (cls[1] == CC_RD) && (cls[0] != CC_RD);

  // state
  src_st_e   st, st_nxt;
  pat_kind_e pat_r;
  logic      sink_r;
  logic      orient_r, orient_nxt;
  logic      disch_r;

  logic pwr_st, att_any;
  assign pwr_st  = (st == ST_SRC) || (st == ST_DBG_UN) || (st == ST_DBG_OR);
  assign att_any = pwr_st || (st == ST_AUDIO);

  // timers
  logic att_done, det_done, err_done, grace_done;
  logic missing;

  always_comb begin
    case (st)
      ST_SRC:              missing = (cls[sink_r] != CC_RD);
      ST_AUDIO:            missing = (pat_now != PAT_AUDIO);
      ST_DBG_UN, ST_DBG_OR: missing = (cls[0] == CC_OPEN) && (cls[1] == CC_OPEN);
      default:             missing = 1'b0;
    endcase
  end

  typec_sat_timer #(.LIMIT(ATT_DEB_CYC)) u_att_tmr (
    .clk(clk), .rst(rst), .clr(st != ST_ATTWAIT), .en(1'b1), .done(att_done));

  typec_sat_timer #(.LIMIT(DET_DEB_CYC)) u_det_tmr (
    .clk(clk), .rst(rst), .clr(!att_any || !missing), .en(1'b1), .done(det_done));

  typec_sat_timer #(.LIMIT(ERR_REC_CYC)) u_err_tmr (
    .clk(clk), .rst(rst), .clr(st != ST_ERR), .en(1'b1), .done(err_done));

  typec_sat_timer #(.LIMIT(VBUS_GRACE_CYC + 1)) u_grace_tmr (
    .clk(clk), .rst(rst), .clr(!pwr_st), .en(1'b1), .done(grace_done));

  // fault merge
  logic fault;
  assign fault = ot_flt || pu_uv_flt || cc_ov_flt ||
                 (pwr_st && ((vdd_uv_en && vdd_uv) || (vdd_ov_en && vdd_ov) ||
                             (grace_done && !vbus_ok)));

  logic match;
  assign match = (pat_now == pat_r) && ((pat_r != PAT_SINK) || (sink_now == sink_r));

  always_comb begin
    st_nxt     = st;
    orient_nxt = orient_r;
    if (st != ST_ERR && fault) begin
      st_nxt     = ST_ERR;
      orient_nxt = 1'b0;
    end else begin
      case (st)
        ST_UNATT: begin
          orient_nxt = 1'b0;
          if (pat_now != PAT_NONE) st_nxt = ST_ATTWAIT;
        end
        ST_ATTWAIT: begin
          if (!match) st_nxt = ST_UNATT;
          else if (att_done) begin
            case (pat_r)
              PAT_AUDIO: st_nxt = ST_AUDIO;
              PAT_SINK:  if (vbus_safe0) begin
                           st_nxt     = ST_SRC;
                           orient_nxt = sink_r;
                         end
              PAT_DEBUG: if (vbus_safe0) st_nxt = ST_DBG_UN;
              default:   st_nxt = ST_UNATT;
            endcase
          end
        end
        ST_DBG_UN: begin
          if (missing && det_done) st_nxt = ST_UNATT;
          else if (cls[0] == CC_RA && cls[1] == CC_RD) begin
            st_nxt     = ST_DBG_OR;
            orient_nxt = 1'b0;
          end else if (cls[0] == CC_RD && cls[1] == CC_RA) begin
            st_nxt     = ST_DBG_OR;
            orient_nxt = 1'b1;
          end
        end
        ST_SRC, ST_AUDIO, ST_DBG_OR: begin
          if (missing && det_done) begin
            st_nxt     = ST_UNATT;
            orient_nxt = 1'b0;
          end
        end
        ST_ERR: begin
          if (err_done) st_nxt = ST_UNATT;
        end
        default: st_nxt = ST_UNATT;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_UNATT;
      pat_r    <= PAT_NONE;
      sink_r   <= 1'b0;
      orient_r <= 1'b0;
      disch_r  <= 1'b0;
    end else begin
      st       <= st_nxt;
      orient_r <= orient_nxt;
      if (st == ST_UNATT) begin
        pat_r  <= pat_now;
        sink_r <= sink_now;
      end
      if (st_nxt == ST_ERR)                    disch_r <= 1'b1;
      else if (att_any && st_nxt == ST_UNATT)  disch_r <= 1'b1;
      else if (st != ST_ERR && vbus_safe0)     disch_r <= 1'b0;
    end
  end

  // output decode from registered state
  always_comb begin
    case (st)
      ST_SRC:    att_mode = MODE_SINK;
      ST_AUDIO:  att_mode = MODE_AUDIO;
      ST_DBG_UN: att_mode = MODE_DBG_UN;
      ST_DBG_OR: att_mode = MODE_DBG_OR;
      default:   att_mode = MODE_NONE;
    endcase
  end

  assign term_en         = (rst || st == ST_ERR) ? 2'b00 : 2'b11;
  assign vconn_en        = (st == ST_SRC) ? (orient_r ? 2'b01 : 2'b10) : 2'b00;
  assign orient_pull_low = orient_r && (st == ST_SRC || st == ST_DBG_OR);
  assign pwr_ok          = pwr_st;
  assign disch_req       = disch_r;

endmodule

// File: rtl/typec_src_ctrl_chk.sv
module typec_src_ctrl_chk (
  input logic       clk,
  input logic       rst,
  input logic [1:0] term_en,
  input logic [1:0] vconn_en,
  input logic       orient_pull_low,
  input logic [2:0] att_mode,
  input logic       pwr_ok,
  input logic       disch_req
);
  always_comb begin
    if (rst) begin
      AST_TERM_HIZ_IN_RESET: assert (term_en == 2'b00); // R1
    end
  end

  AST_PWR_ONLY_ATTACHED: assert property (@(posedge clk) disable iff (rst)
    pwr_ok |-> (att_mode == 3'd1 || att_mode == 3'd3 || att_mode == 3'd4)); // R13

  AST_VCONN_OPPOSITE: assert property (@(posedge clk) disable iff (rst)
    (vconn_en != 2'b00) |-> ((vconn_en == 2'b01 && orient_pull_low) ||
                             (vconn_en == 2'b10 && !orient_pull_low))); // R5

  AST_ORIENT_ATTACHED: assert property (@(posedge clk) disable iff (rst)
    orient_pull_low |-> (att_mode == 3'd1 || att_mode == 3'd4)); // R5

  AST_RECOVERY_SAFE: assert property (@(posedge clk) disable iff (rst)
    (term_en == 2'b00) |-> (!pwr_ok && disch_req && vconn_en == 2'b00)); // R9

  AST_DISCH_ON_DETACH: assert property (@(posedge clk) disable iff (rst)
    (att_mode == 3'd0 && $past(att_mode) != 3'd0) |-> disch_req); // R8
endmodule

bind typec_src_ctrl typec_src_ctrl_chk u_chk (.*);

// File: tb/tb_typec_src_ctrl.sv
module tb_typec_src_ctrl;
  localparam int ATT = 16;
  localparam int DET = 6;
  localparam int ERC = 10;
  localparam int GRC = 20;

  logic       clk = 1'b0;
  logic       rst;
  logic [1:0] cur_sel;
  logic [2:0] cc1_cmp, cc2_cmp;
  logic       vbus_ok, vbus_safe0, ot_flt, pu_uv_flt, cc_ov_flt;
  logic       vdd_uv, vdd_ov, vdd_uv_en, vdd_ov_en;
  logic [1:0] rp_level, term_en, vconn_en;
  logic       orient_pull_low, pwr_ok, disch_req;
  logic [2:0] att_mode;

  int n_chk  = 0;
  int n_fail = 0;
  bit ended  = 0;

  always #2 clk = ~clk;

  typec_src_ctrl #(
    .ATT_DEB_CYC(ATT), .DET_DEB_CYC(DET), .ERR_REC_CYC(ERC), .VBUS_GRACE_CYC(GRC)
  ) dut (.*);

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  // level 0 lowest voltage .. 3 open
  function automatic logic [2:0] lvl2cmp(input int l);
    case (l)
      0: return 3'b111;
      1: return 3'b110;
      2: return 3'b100;
      default: return 3'b000;
    endcase
  endfunction

  // 0 open, 1 Rd, 2 Ra
  function automatic int exp_cls(input int l, input bit hi);
    if (l == 0) return 2;
    if (l == 1) return hi ? 2 : 1;
    if (l == 2) return 1;
    return 0;
  endfunction

  function automatic int exp_mode(input int a, input int b);
    if (a == 2 && b == 2) return 2;
    if (a == 1 && b == 1) return 3;
    if (a == 1 || b == 1) return 1;
    return 0;
  endfunction

  task automatic pins(input int l1, input int l2);
    cc1_cmp = lvl2cmp(l1);
    cc2_cmp = lvl2cmp(l2);
  endtask

  task automatic detach_all();
    pins(3, 3);
    step(DET + 3);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned seed_dummy;
    seed_dummy = $urandom(32'd4242);
    rst = 1; cur_sel = 0; pins(3, 3);
    vbus_ok = 1; vbus_safe0 = 1; ot_flt = 0; pu_uv_flt = 0; cc_ov_flt = 0;
    vdd_uv = 0; vdd_ov = 0; vdd_uv_en = 0; vdd_ov_en = 0;
    step(3);
    chk("R1 term in reset", term_en, 0);
    chk("R1 mode in reset", att_mode, 0);
    rst = 0;
    step(2);
    chk("R1 term after reset", term_en, 3);
    chk("R1 pwr after reset", pwr_ok, 0);
    chk("R1 orient after reset", orient_pull_low, 0);

    // R12 current selection
    cur_sel = 2; step(1); chk("R12 3A0", rp_level, 2);
    cur_sel = 3; step(1); chk("R12 code3", rp_level, 2);
    cur_sel = 1; step(1); chk("R12 1A5", rp_level, 1);
    cur_sel = 0; step(1); chk("R12 default", rp_level, 0);

    // R3 exact debounce, sink on CC1
    pins(2, 3);
    step(ATT + 1); chk("R3 before debounce end", att_mode, 0);
    step(1);       chk("R3 at debounce end", att_mode, 1);
    chk("R5 orient cc1", orient_pull_low, 0);
    chk("R5 vconn cc2", vconn_en, 2);
    chk("R13 pwr sink", pwr_ok, 1);

    // R8 detach timing and discharge
    pins(3, 3);
    step(DET); chk("R8 before detach", att_mode, 1);
    step(1);   chk("R8 detach", att_mode, 0);
    chk("R8 disch raised", disch_req, 1);
    step(1);   chk("R8 disch cleared", disch_req, 0);
    step(2);

    // R5 sink on CC2
    pins(3, 2);
    step(ATT + 3);
    chk("R5 mode", att_mode, 1);
    chk("R5 orient cc2", orient_pull_low, 1);
    chk("R5 vconn cc1", vconn_en, 1);
    detach_all();

    // R4 safe0 requirement
    vbus_safe0 = 0;
    pins(2, 3);
    step(ATT + 6); chk("R4 held without safe0", att_mode, 0);
    vbus_safe0 = 1;
    step(1);       chk("R4 attach on safe0", att_mode, 1);
    detach_all();

    // R6 audio, no safe0 needed
    vbus_safe0 = 0;
    pins(0, 0);
    step(ATT + 3);
    chk("R6 audio mode", att_mode, 2);
    chk("R6 audio no pwr", pwr_ok, 0);
    chk("R6 audio no vconn", vconn_en, 0);
    detach_all();
    chk("R8 audio detach", att_mode, 0);
    vbus_safe0 = 1;
    step(2);

    // R7 debug accessory
    pins(2, 2);
    step(ATT + 3);
    chk("R7 debug unoriented", att_mode, 3);
    chk("R13 pwr debug", pwr_ok, 1);
    pins(2, 0);
    step(2);
    chk("R7 debug oriented", att_mode, 4);
    chk("R7 debug orient cc2", orient_pull_low, 1);
    detach_all();
    chk("R8 debug detach", att_mode, 0);

    // R3 restart on pattern change
    pins(2, 3); step(8);
    pins(3, 2);
    step(ATT + 1); chk("R3 restart holds", att_mode, 0);
    step(2);       chk("R3 restart attach", att_mode, 1);
    chk("R3 restart orient", orient_pull_low, 1);
    detach_all();

    // R2 current-dependent boundary
    cur_sel = 2; step(2);
    pins(1, 3);
    step(ATT + 3); chk("R2 level1 is Ra at 3A0", att_mode, 0);
    cur_sel = 0;
    step(ATT + 5); chk("R2 level1 is Rd at default", att_mode, 1);
    detach_all();

    // R10 grace window
    pins(2, 3);
    step(ATT + 3); chk("R10 attached", att_mode, 1);
    vbus_ok = 0; step(GRC - 6);
    chk("R10 ignored in grace", att_mode, 1);
    vbus_ok = 1; step(GRC);
    vbus_ok = 0; step(1);
    chk("R10 fault after grace", term_en, 0);
    chk("R9 pwr off in recovery", pwr_ok, 0);
    chk("R9 disch in recovery", disch_req, 1);
    vbus_ok = 1;
    step(ERC - 1); chk("R9 still recovering", term_en, 0);
    step(1);       chk("R9 recovery ends", term_en, 3);
    chk("R9 back unattached", att_mode, 0);
    detach_all();

    // R11 supply checks gated by enables
    pins(2, 3);
    step(ATT + 3);
    vdd_uv = 1; vdd_ov = 1; step(3);
    chk("R11 disabled checks ignored", att_mode, 1);
    vdd_ov_en = 1; step(1);
    chk("R11 enabled ov check", term_en, 0);
    vdd_uv = 0; vdd_ov = 0; vdd_ov_en = 0;
    pins(3, 3);
    step(ERC + 2);
    chk("R11 recovered", term_en, 3);

    // R9 fault while unattached
    ot_flt = 1; step(1); ot_flt = 0;
    chk("R9 thermal fault", term_en, 0);
    step(ERC);
    chk("R9 thermal recovery end", term_en, 3);
    cc_ov_flt = 1; step(1); cc_ov_flt = 0;
    chk("R9 cc ov fault", term_en, 0);
    step(ERC + 1);

    // random patterns (R2)
    for (int i = 0; i < 40; i++) begin
      int l1, l2, m;
      bit hi;
      l1 = int'($urandom % 4);
      l2 = int'($urandom % 4);
      hi = 1'($urandom % 2);
      cur_sel = hi ? 2'd2 : 2'd0;
      step(2);
      pins(l1, l2);
      step(ATT + 5);
      m = exp_mode(exp_cls(l1, hi), exp_cls(l2, hi));
      chk("R2 random pattern mode", att_mode, m);
      chk("R13 random pwr", pwr_ok, (m == 1 || m == 3) ? 1 : 0);
      detach_all();
      chk("R8 random detach", att_mode, 0);
    end

    ended = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule